// File: doc/BRIEF.md
# Panel Power-Up Sequencer

This block brings up a flat panel by asserting five enables one after another: panel supply, LVDS transmitter, backlight supply, backlight PWM and backlight enable. The gaps between steps are programmed in milliseconds. Time is measured by counting an external microsecond tick, and a fixed number of ticks makes one millisecond. An enable whose hardware is missing on a given board can be masked off. The masked step still takes its place in the order and still waits out its gap, but its output never rises.

Stepping is driven by a request input and can work in two ways. In polled mode, each request advances at most one step, and only when that step's gap has already elapsed. A request that arrives too early does nothing. In blocking mode, a single request sets the block running, and it then takes every remaining step by itself as soon as each gap elapses. When the backlight enable step has been taken, the done flag rises. From then on the block ignores all requests until the next synchronous reset.

Top module: `panel_pwr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, every enable, `pwm_duty_o`, `pwm_period_o` and `done_o` are 0 after that edge, and the sequence returns to its start point.
- R2: The enables rise only in this order: panel supply, LVDS, backlight supply, PWM, backlight enable. At most one step is taken per clock edge. A taken step's output is high right after the edge that samples the request (or, in a blocking run, right after the edge that sees the gap expired).
- R3: At the start point, a request takes the panel supply step at the next edge, without waiting for any tick.
- R4: `gap_ms_i` holds four 16-bit fields. Field g, at bits [16g+15:16g], is the gap before step g+2 (g=0: LVDS, g=1: backlight supply, g=2: PWM, g=3: backlight enable). A gap of D expires once D*1000+1 ticks have been sampled at edges strictly after the edge that took the previous step. A step can be taken at an edge only if its gap had already expired before that edge. A gap of 0 therefore allows the step two edges after the previous one when a tick arrives in between.
- R5: In polled mode (`block_i`=0 with `req_i`=1), a request before expiry has no effect, and one request takes at most one step.
- R6: A request with `block_i`=1 starts a run. The run takes each remaining step at the first edge after that step's gap has expired, with no further requests, until done.
- R7: `present_i` bit 0 is panel supply, bit 1 LVDS, bit 2 backlight supply, bit 3 PWM and bit 4 backlight enable. A step whose bit is 0 when it is taken is still sequenced and timed, but its output stays 0.
- R8: While the PWM enable is high, `pwm_duty_o` is 0xDF and `pwm_period_o` is 0xFF. Both are 0 while it is low.
- R9: `done_o` rises on the same edge as the backlight enable step. After that, requests in either mode change no output.
- R10: An enable that has been asserted stays asserted until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Step or run request |
| block_i | input | 1 | With `req_i`: 1 starts a blocking run, 0 is a polled step |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| gap_ms_i | input | 64 | Four 16-bit millisecond gaps, field g before step g+2 |
| present_i | input | 5 | Per-output fitted mask |
| panel_vdd_en_o | output | 1 | Panel supply enable |
| lvds_en_o | output | 1 | LVDS transmitter enable |
| bl_vdd_en_o | output | 1 | Backlight supply enable |
| pwm_en_o | output | 1 | Backlight PWM enable |
| pwm_duty_o | output | 8 | PWM high count |
| pwm_period_o | output | 8 | PWM period count |
| bl_en_o | output | 1 | Backlight enable |
| done_o | output | 1 | Sequence complete |

## Verification
A wrong step index or a wrong run flag shows up as an enable rising too soon, too late or out of order. The bench model catches this at the very negative edge after the offending clock edge, because it compares all outputs every cycle. A timer that is off by one tick moves an enable by one cycle, so zero-gap and exact-window cases are checked to the cycle. Masked steps are harder to observe, since their outputs never move. Their timing is instead seen through the delay of the next fitted output.

// File: rtl/pps_pkg.sv
package pps_pkg;

    localparam int NUM_RAILS = 5;
    localparam int NUM_GAPS  = 4;

    // Count of steps already taken; START means none taken yet.
    typedef enum logic [2:0] {
        ST_START = 3'd0,
        ST_PANEL = 3'd1,
        ST_LVDS  = 3'd2,
        ST_BLVDD = 3'd3,
        ST_PWM   = 3'd4,
        ST_DONE  = 3'd5
    } pps_step_e;

    typedef struct packed {
        pps_step_e step;
        logic      run;
    } pps_ctrl_s;

endpackage

// File: rtl/pps_ms_timer.sv
module pps_ms_timer #(
    parameter int DW        = 16,
    parameter int US_PER_MS = 1000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart_i,
    input  logic [DW-1:0] load_ms_i,
    input  logic          tick_i,
    output logic          expired_o
);
    localparam int UW = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;
    localparam logic [UW-1:0] US_LAST = UW'(US_PER_MS - 1);

    typedef struct packed {
        logic [UW-1:0] us;
        logic [DW-1:0] ms;
        logic          ex;
    } tmr_s;

    tmr_s t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (restart_i) begin
            t_d.us = '0;
            t_d.ms = load_ms_i;
            t_d.ex = 1'b0;
        end else if (tick_i && !t_q.ex) begin
            if (t_q.ms == '0) begin
                t_d.ex = 1'b1;
            end else if (t_q.us == US_LAST) begin
                t_d.us = '0;
                t_d.ms = t_q.ms - 1'b1;
            end else begin
                t_d.us = t_q.us + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign expired_o = t_q.ex;
endmodule

// File: rtl/pps_gap_select.sv
module pps_gap_select #(
    parameter int DW = 16,
    parameter int NG = 4,
    localparam int IW = (NG > 1) ? $clog2(NG) : 1
) (
    input  logic [NG*DW-1:0] gaps_i,
    input  logic [IW-1:0]    idx_i,
    output logic [DW-1:0]    gap_o
);
    logic [DW-1:0] field [NG];

    for (genvar g = 0; g < NG; g++) begin : g_unpack
        assign field[g] = gaps_i[g*DW +: DW];
    end

    always_comb begin
        gap_o = '0;
        for (int g = 0; g < NG; g++) begin
            if (idx_i == IW'(g)) gap_o = field[g];
        end
    end
endmodule

// File: rtl/pps_rail_bank.sv
module pps_rail_bank #(
    parameter int NR = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire_i,
    input  logic [2:0]    step_i,
    input  logic [NR-1:0] present_i,
    output logic [NR-1:0] rail_o
);
    logic [NR-1:0] rail_d, rail_q;

    for (genvar j = 0; j < NR; j++) begin : g_rail
        assign rail_d[j] = rail_q[j] | (fire_i && (step_i == 3'(j)) && present_i[j]);
    end

    always_ff @(posedge clk) begin
        if (rst) rail_q <= '0;
        else     rail_q <= rail_d;
    end

    assign rail_o = rail_q;
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
    import pps_pkg::*;
#(
    parameter int            DW         = 16,
    parameter int            US_PER_MS  = 1000,
    parameter int            PWM_W      = 8,
    parameter logic [PWM_W-1:0] PWM_DUTY   = 8'hDF,
    parameter logic [PWM_W-1:0] PWM_PERIOD = 8'hFF
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_i,
    input  logic                   block_i,
    input  logic                   us_tick_i,
    input  logic [NUM_GAPS*DW-1:0] gap_ms_i,
    input  logic [NUM_RAILS-1:0]   present_i,
    output logic                   panel_vdd_en_o,
    output logic                   lvds_en_o,
    output logic                   bl_vdd_en_o,
    output logic                   pwm_en_o,
    output logic [PWM_W-1:0]       pwm_duty_o,
    output logic [PWM_W-1:0]       pwm_period_o,
    output logic                   bl_en_o,
    output logic                   done_o
);
    localparam int IW = (NUM_GAPS > 1) ? $clog2(NUM_GAPS) : 1;

    pps_ctrl_s            st_d, st_q;
    logic                 fire;
    logic                 tmr_expired;
    logic [DW-1:0]        next_gap;
    logic [NUM_RAILS-1:0] rails;

    always_comb begin
        st_d = st_q;
        unique case (st_q.step)
            ST_START: fire = req_i;
            ST_DONE:  fire = 1'b0;
            default:  fire = tmr_expired && (st_q.run || req_i);
        endcase
        if (fire) st_d.step = pps_step_e'(st_q.step + 3'd1);
        if ((st_q.step != ST_DONE) && req_i && block_i) st_d.run = 1'b1;
        if (st_d.step == ST_DONE) st_d.run = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{step: ST_START, run: 1'b0};
        else     st_q <= st_d;
    end

    pps_gap_select #(.DW(DW), .NG(NUM_GAPS)) u_gap_sel (
        .gaps_i (gap_ms_i),
        .idx_i  (st_q.step[IW-1:0]),
        .gap_o  (next_gap)
    );

    pps_ms_timer #(.DW(DW), .US_PER_MS(US_PER_MS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart_i (fire),
        .load_ms_i (next_gap),
        .tick_i    (us_tick_i),
        .expired_o (tmr_expired)
    );

    pps_rail_bank #(.NR(NUM_RAILS)) u_rails (
        .clk       (clk),
        .rst       (rst),
        .fire_i    (fire),
        .step_i    (st_q.step),
        .present_i (present_i),
        .rail_o    (rails)
    );

    assign panel_vdd_en_o = rails[0];
    assign lvds_en_o      = rails[1];
    assign bl_vdd_en_o    = rails[2];
    assign pwm_en_o       = rails[3];
    assign bl_en_o        = rails[4];
    assign pwm_duty_o     = rails[3] ? PWM_DUTY   : '0;
    assign pwm_period_o   = rails[3] ? PWM_PERIOD : '0;
    assign done_o         = (st_q.step == ST_DONE);
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
    parameter int               PWM_W      = 8,
    parameter logic [PWM_W-1:0] PWM_DUTY   = 8'hDF,
    parameter logic [PWM_W-1:0] PWM_PERIOD = 8'hFF
) (
    input logic             clk,
    input logic             rst,
    input logic             req_i,
    input logic [4:0]       present_i,
    input logic [2:0]       step_i,
    input logic             tmr_exp_i,
    input logic [4:0]       rails_i,
    input logic [PWM_W-1:0] duty_i,
    input logic [PWM_W-1:0] period_i,
    input logic             done_i
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!done_i && rails_i == 5'd0 && duty_i == '0 && period_i == '0));

    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && step_i != $past(step_i)) |-> (step_i == $past(step_i) + 3'd1));

    a_r3_start_no_wait: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(step_i) == 3'd0 && $past(req_i)) |-> (step_i == 3'd1));

    a_r4_waits_expiry: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && step_i != $past(step_i) && $past(step_i) != 3'd0) |-> $past(tmr_exp_i));

    a_r7_absent_stays_low: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (rails_i & ~$past(rails_i)) != 5'd0)
        |-> ((rails_i & ~$past(rails_i) & ~$past(present_i)) == 5'd0));

    a_r8_duty_value: assert property (@(posedge clk) disable iff (rst)
        (duty_i != '0) |-> (duty_i == PWM_DUTY && period_i == PWM_PERIOD && rails_i[3]));

    a_r9_done_frozen: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(done_i)) |-> (done_i && rails_i == $past(rails_i)));

    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((rails_i & $past(rails_i)) == $past(rails_i)));
endmodule

bind panel_pwr_seq pps_checker #(
    .PWM_W      (PWM_W),
    .PWM_DUTY   (PWM_DUTY),
    .PWM_PERIOD (PWM_PERIOD)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req_i),
    .present_i (present_i),
    .step_i    (st_q.step),
    .tmr_exp_i (tmr_expired),
    .rails_i   ({bl_en_o, pwm_en_o, bl_vdd_en_o, lvds_en_o, panel_vdd_en_o}),
    .duty_i    (pwm_duty_o),
    .period_i  (pwm_period_o),
    .done_i    (done_o)
);

// File: tb/panel_pwr_seq_tb.sv
module panel_pwr_seq_tb;
    localparam int US = 1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0;
    logic        block_i = 1'b0;
    logic        us_tick_i = 1'b0;
    logic [63:0] gap_ms_i = '0;
    logic [4:0]  present_i = 5'h1F;
    logic        panel_vdd_en_o, lvds_en_o, bl_vdd_en_o, pwm_en_o, bl_en_o, done_o;
    logic [7:0]  pwm_duty_o, pwm_period_o;

    always #10 clk = ~clk;

    panel_pwr_seq u_dut (
        .clk(clk), .rst(rst), .req_i(req_i), .block_i(block_i), .us_tick_i(us_tick_i),
        .gap_ms_i(gap_ms_i), .present_i(present_i),
        .panel_vdd_en_o(panel_vdd_en_o), .lvds_en_o(lvds_en_o), .bl_vdd_en_o(bl_vdd_en_o),
        .pwm_en_o(pwm_en_o), .pwm_duty_o(pwm_duty_o), .pwm_period_o(pwm_period_o),
        .bl_en_o(bl_en_o), .done_o(done_o)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0, tick_every = 1;
    logic finished = 1'b0;

    wire [4:0] rails = {bl_en_o, pwm_en_o, bl_vdd_en_o, lvds_en_o, panel_vdd_en_o};

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    // Behavioural reference: steps taken, ticks since the last step, run flag.
    int       m_step = 0, m_ticks = 0, m_delay = 0;
    logic     m_run = 1'b0, m_live = 1'b0;
    logic [4:0] m_rail = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_step = 0; m_ticks = 0; m_delay = 0; m_run = 1'b0; m_rail = '0; m_live = 1'b1;
        end else begin
            automatic bit expired = (m_ticks > m_delay * US);
            automatic bit go;
            automatic bit old_run = m_run;
            if (m_step != 5 && req_i && block_i) m_run = 1'b1;
            if (m_step == 0)      go = req_i;
            else if (m_step == 5) go = 1'b0;
            else                  go = expired && (old_run || req_i);
            if (go) begin
                if (present_i[m_step]) m_rail[m_step] = 1'b1;
                if (m_step < 4) m_delay = int'((gap_ms_i >> (16 * m_step)) & 64'hFFFF);
                m_step++;
                m_ticks = 0;
            end else if (us_tick_i && m_ticks < 100000000) begin
                m_ticks++;
            end
            if (m_step == 5) m_run = 1'b0;
        end
    end

    always @(negedge clk) begin
        cyc++;
        us_tick_i <= (cyc % tick_every == 0);
        if (m_live && !finished) begin
            chk("R2 enables", {27'd0, rails}, {27'd0, m_rail});
            chk("R8 duty/period", {16'd0, pwm_duty_o, pwm_period_o},
                m_rail[3] ? 32'h0000DFFF : 32'h0);
            chk("R9 done", {31'd0, done_o}, {31'd0, (m_step == 5)});
        end
    end

    task automatic report();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            report();
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic blk);
        req_i = 1'b1; block_i = blk;
        @(negedge clk);
        req_i = 1'b0; block_i = 1'b0;
    endtask

    task automatic wait_done(input int lim);
        for (int i = 0; i < lim && !done_o; i++) @(negedge clk);
    endtask

    logic [4:0] snap;

    initial begin
        idle(3);
        chk("R1 enables after reset", {27'd0, rails}, 32'd0);
        chk("R1 done after reset", {31'd0, done_o}, 32'd0);
        rst = 1'b0;

        // Polled run, all fitted; gaps g0=1 g1=0 g2=2 g3=1
        gap_ms_i = {16'd1, 16'd2, 16'd0, 16'd1};
        idle(2);
        pulse(1'b0);
        chk("R3 panel at once", {31'd0, panel_vdd_en_o}, 32'd1);
        pulse(1'b0);
        chk("R5 early request", {31'd0, lvds_en_o}, 32'd0);
        idle(500);
        pulse(1'b0);
        chk("R5 request inside gap", {31'd0, lvds_en_o}, 32'd0);
        idle(600);
        pulse(1'b0);
        chk("R4 lvds after gap", {31'd0, lvds_en_o}, 32'd1);
        chk("R5 one step per request", {31'd0, bl_vdd_en_o}, 32'd0);
        pulse(1'b0);
        chk("R4 zero gap not yet", {31'd0, bl_vdd_en_o}, 32'd0);
        pulse(1'b0);
        chk("R4 zero gap after one tick", {31'd0, bl_vdd_en_o}, 32'd1);

        // Switch to a blocking run for the rest
        pulse(1'b1);
        chk("R6 pwm waits its gap", {31'd0, pwm_en_o}, 32'd0);
        wait_done(10000);
        chk("R6 run reaches done", {31'd0, done_o}, 32'd1);
        chk("R8 duty when on", {24'd0, pwm_duty_o}, 32'hDF);
        snap = rails;
        pulse(1'b0);
        pulse(1'b1);
        idle(20);
        chk("R9 requests ignored", {27'd0, rails}, {27'd0, snap});
        chk("R10 panel still on", {31'd0, panel_vdd_en_o}, 32'd1);

        // Reset clears, then blocking run with LVDS and PWM absent
        rst = 1'b1; idle(1); rst = 1'b0;
        chk("R1 reset clears enables", {27'd0, rails}, 32'd0);
        present_i = 5'b10101;
        gap_ms_i = {16'd2, 16'd0, 16'd1, 16'd0};
        tick_every = 2;
        pulse(1'b1);
        wait_done(20000);
        chk("R6 blocking done", {31'd0, done_o}, 32'd1);
        chk("R7 absent outputs low", {30'd0, lvds_en_o, pwm_en_o}, 32'd0);
        chk("R7 fitted outputs high", {29'd0, panel_vdd_en_o, bl_vdd_en_o, bl_en_o}, 32'd7);
        chk("R8 duty off without pwm", {24'd0, pwm_duty_o}, 32'd0);

        // Held polled request with zero gaps and sparse ticks
        rst = 1'b1; idle(1); rst = 1'b0;
        present_i = 5'h1F;
        gap_ms_i = '0;
        tick_every = 3;
        req_i = 1'b1;
        idle(40);
        req_i = 1'b0;
        chk("R5 held polled request completes", {31'd0, done_o}, 32'd1);

        // Reset mid-sequence
        tick_every = 1;
        rst = 1'b1; idle(1); rst = 1'b0;
        gap_ms_i = {16'd1, 16'd1, 16'd1, 16'd1};
        pulse(1'b0);
        idle(5);
        chk("R10 held until reset", {31'd0, panel_vdd_en_o}, 32'd1);
        rst = 1'b1; idle(1); rst = 1'b0;
        chk("R1 mid-run reset", {27'd0, rails}, 32'd0);
        idle(3);
        report();
    end
endmodule